// File: doc/BRIEF.md
# Word-Packed I2C Bus Master

This block is a single-master I2C controller run through four 32-bit registers. Software gives it a 7-bit target address, a transfer direction and a byte total. It then writes a 32-bit word into the data register. That write launches the transfer: a START, then the address byte, then data bytes taken from the word most significant byte first. When a word has been drained and bytes still remain, the block raises a refill flag. It then parks the bus with SCL held low until software supplies the next word. Reads work the other way round: arriving bytes are packed into the data register from the top byte down.

A remaining-bytes counter can be read at any time. On writes it steps down when a byte moves into the bit shifter, which is ahead of the byte reaching the wire. Four status flags report completion, an unanswered address, a refused data byte and a refill request. Each flag has an enable bit feeding a single interrupt line and a write-one clear bit. The SCL and SDA outputs are open-drain style enables derived from a programmable quarter-bit divider. A software mode hands both lines to two control-register bits.

Top module: `i2c_word_master`

## Requirements
- R1: Register offsets are 0 control, 1 target, 2 data, 3 status. Target holds the address in [6:0], the direction in [7] (0 write, 1 read) and the byte total in [15:8]. A data write while idle and enabled emits a START and then the byte {address, direction}.
- R2: On a write transfer, the bytes of the data word go out in the order [31:24], [23:16], [15:8], [7:0], for exactly the programmed total.
- R3: The byte total in target [15:8] drops by one for each data byte. On writes it drops when the byte is loaded into the shifter, before that byte is clocked onto the bus.
- R4: Once the fourth byte of a write word has been loaded and bytes remain, status flag [3] (refill) is set. When the shifter needs a byte and no word is present, SCL is held low until the data register is written.
- R5: On a read, byte n of a word lands in data bits [31-8n -: 8]. The master acknowledges every byte except the final one, which it does not acknowledge. After the final byte comes a STOP, and then status flag [0] (done) is set.
- R6: If the address byte is not acknowledged, status flag [1] is set, a STOP follows, no data byte moves, the byte total stays unchanged and done stays clear.
- R7: If a written data byte is not acknowledged, status flag [2] is set, a STOP follows and the transfer ends with the byte total showing the unloaded bytes.
- R8: Control bits [7:4] written as one clear the matching status flags [3:0]. Flags that are not selected keep their value.
- R9: The interrupt output is high exactly when some status flag [k] is set together with control enable bit [k], for k in 0..3.
- R10: Status [4] and [5] show the live SDA and SCL line levels, and status [6] shows busy. With control [9] set, SDA follows control [10], SCL follows control [11], and a data write starts nothing.
- R11: With control [8] (enable) clear, a data write starts no transfer and both lines stay released.
- R12: Within a data or acknowledge bit, SDA changes only while SCL is low. Only START and STOP move SDA while SCL is high.
- R13: After reset no flag is set, the interrupt is low, the block is idle and both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The write path is tried with full words, partial words and a word pair that forces a refill stall. Together these separate correct byte order and count handling from off-by-one loading. The read path is tried with totals of one and three bytes, which shows whether bytes are packed from the top down and whether only the last byte is refused. A zero total, a wrong address and a refused second byte each end the transfer at a different point, which separates the address-phase and data-phase error exits. The software line mode and the disable bit are driven with the same data-register write so that any unwanted start shows up on the lines.

// File: rtl/i2c_wm_pkg.sv
package i2c_wm_pkg;

    typedef enum logic [1:0] {
        CMD_START,
        CMD_STOP,
        CMD_WBIT,
        CMD_RBIT
    } bus_cmd_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_START,
        SQ_ADDR,
        SQ_AACK,
        SQ_WBYTE,
        SQ_WACK,
        SQ_WAIT,
        SQ_RBYTE,
        SQ_RACK,
        SQ_STOP
    } seq_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_TGT  = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int NFLAG     = 4;
    localparam int FL_DONE   = 0;
    localparam int FL_ANACK  = 1;
    localparam int FL_DNACK  = 2;
    localparam int FL_REFILL = 3;

endpackage

// File: rtl/i2c_wm_tick.sv
module i2c_wm_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tick_t;

    tick_t q, n;

    always_comb begin
        n    = q;
        tick = (q.cnt >= div);
        if (tick) n.cnt = '0;
        else      n.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= n;
    end
endmodule

// File: rtl/i2c_wm_phy.sv
module i2c_wm_phy
    import i2c_wm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     cmd_valid,
    input  bus_cmd_e cmd,
    input  logic     cmd_bit,
    input  logic     sda_in,
    output logic     busy,
    output logic     done,
    output logic     rbit,
    output logic     sda_o,
    output logic     scl_o
);
    typedef struct packed {
        logic     busy;
        bus_cmd_e cmd;
        logic     bitv;
        logic [1:0] ph;
        logic     rbit;
        logic     sda;
        logic     scl;
        logic     done;
    } phy_t;

    phy_t q, n;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        if (!q.busy && cmd_valid) begin
            n.busy = 1'b1;
            n.cmd  = cmd;
            n.bitv = cmd_bit;
            n.ph   = 2'd0;
        end else if (q.busy && tick) begin
            case (q.cmd)
                CMD_START: begin
                    n.sda = (q.ph == 2'd0);
                    n.scl = (q.ph != 2'd3);
                end
                CMD_STOP: begin
                    n.sda = q.ph[1];
                    n.scl = (q.ph != 2'd0);
                end
                default: begin
                    n.sda = (q.cmd == CMD_RBIT) ? 1'b1 : q.bitv;
                    n.scl = (q.ph == 2'd1) || (q.ph == 2'd2);
                end
            endcase
            if (q.cmd == CMD_RBIT && q.ph == 2'd2) n.rbit = sda_in;
            n.ph = q.ph + 2'd1;
            if (q.ph == 2'd3) begin
                n.busy = 1'b0;
                n.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.cmd  <= CMD_STOP;
            q.sda  <= 1'b1;
            q.scl  <= 1'b1;
            q.rbit <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy  = q.busy;
    assign done  = q.done;
    assign rbit  = q.rbit;
    assign sda_o = q.sda;
    assign scl_o = q.scl;

    // R12: data and acknowledge bits never move SDA during the SCL high time
    assert_sda_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (q.scl && $past(q.scl) && (q.cmd == CMD_WBIT || q.cmd == CMD_RBIT)
         && $past(q.cmd) == q.cmd) |-> $stable(q.sda));

    // R12: the sequencer only hands over a command when the bit engine is free
    assert_cmd_idle_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !q.busy);
endmodule

// File: rtl/i2c_word_master.sv
module i2c_word_master
    import i2c_wm_pkg::*;
#(
    parameter int               CNT_W     = 8,
    parameter int               DIV_W     = 16,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'd24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        scl_oe,
    output logic        sda_oe
);
    localparam int CNT_LSB = 8;
    localparam int DIV_LSB = 16;

    typedef struct packed {
        seq_state_e       st;
        logic             issued;
        logic             err;
        logic [2:0]       bitn;
        logic [7:0]       sh;
        logic [31:0]      data;
        logic [1:0]       bidx;
        logic             wfull;
        logic [6:0]       slv;
        logic             dir;
        logic [CNT_W-1:0] cnt;
        logic [NFLAG-1:0] ie;
        logic [NFLAG-1:0] flags;
        logic             en;
        logic             swm;
        logic             swsda;
        logic             swscl;
        logic [DIV_W-1:0] div;
    } ctl_t;

    ctl_t q, n;

    logic       tick;
    logic       cmd_valid;
    bus_cmd_e   cmd;
    logic       cmd_bit;
    logic       phy_busy, phy_done, phy_rbit, phy_sda, phy_scl;
    logic [NFLAG-1:0] set_f, clr_f;
    logic       do_load, ack_ok, tgt_wr;
    logic [4:0] byte_lsb;

    i2c_wm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (q.div),
        .tick (tick)
    );

    i2c_wm_phy u_phy (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_bit   (cmd_bit),
        .sda_in    (sda_in),
        .busy      (phy_busy),
        .done      (phy_done),
        .rbit      (phy_rbit),
        .sda_o     (phy_sda),
        .scl_o     (phy_scl)
    );

    always_comb begin
        n         = q;
        set_f     = '0;
        clr_f     = '0;
        do_load   = 1'b0;
        ack_ok    = 1'b0;
        cmd       = CMD_START;
        cmd_bit   = 1'b1;
        byte_lsb  = {~q.bidx, 3'b000};
        tgt_wr    = reg_we && (reg_addr == REG_TGT);

        // host side
        if (reg_we) begin
            case (reg_addr)
                REG_CTRL: begin
                    n.ie    = reg_wdata[NFLAG-1:0];
                    clr_f   = reg_wdata[2*NFLAG-1:NFLAG];
                    n.en    = reg_wdata[8];
                    n.swm   = reg_wdata[9];
                    n.swsda = reg_wdata[10];
                    n.swscl = reg_wdata[11];
                    n.div   = reg_wdata[DIV_LSB +: DIV_W];
                end
                REG_TGT: begin
                    n.slv = reg_wdata[6:0];
                    n.dir = reg_wdata[7];
                    n.cnt = reg_wdata[CNT_LSB +: CNT_W];
                end
                REG_DATA: begin
                    n.data  = reg_wdata;
                    n.wfull = 1'b1;
                    n.bidx  = 2'd0;
                    if (q.st == SQ_IDLE && q.en && !q.swm) begin
                        n.st     = SQ_START;
                        n.issued = 1'b0;
                        n.err    = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        // command selection for the bit engine
        case (q.st)
            SQ_START:                   cmd = CMD_START;
            SQ_ADDR, SQ_WBYTE:          begin cmd = CMD_WBIT; cmd_bit = q.sh[7]; end
            SQ_AACK, SQ_WACK, SQ_RBYTE: cmd = CMD_RBIT;
            SQ_RACK:                    begin cmd = CMD_WBIT; cmd_bit = (q.cnt == '0); end
            default:                    cmd = CMD_STOP;
        endcase
        cmd_valid = !q.issued && (q.st != SQ_IDLE) && (q.st != SQ_WAIT);
        if (cmd_valid) n.issued = 1'b1;

        // sequencer
        if (phy_done) begin
            n.issued = 1'b0;
            case (q.st)
                SQ_START: begin
                    n.st   = SQ_ADDR;
                    n.sh   = {q.slv, q.dir};
                    n.bitn = 3'd7;
                end
                SQ_ADDR, SQ_WBYTE: begin
                    n.sh   = {q.sh[6:0], 1'b0};
                    n.bitn = q.bitn - 3'd1;
                    if (q.bitn == 3'd0) n.st = (q.st == SQ_ADDR) ? SQ_AACK : SQ_WACK;
                end
                SQ_AACK: begin
                    if (phy_rbit) begin
                        set_f[FL_ANACK] = 1'b1;
                        n.err           = 1'b1;
                        n.st            = SQ_STOP;
                    end else begin
                        ack_ok = 1'b1;
                    end
                end
                SQ_WACK: begin
                    if (phy_rbit) begin
                        set_f[FL_DNACK] = 1'b1;
                        n.err           = 1'b1;
                        n.st            = SQ_STOP;
                    end else begin
                        ack_ok = 1'b1;
                    end
                end
                SQ_RBYTE: begin
                    n.sh = {q.sh[6:0], phy_rbit};
                    if (q.bitn == 3'd0) begin
                        n.data[byte_lsb +: 8] = {q.sh[6:0], phy_rbit};
                        n.cnt  = q.cnt - 1'b1;
                        n.bidx = q.bidx + 2'd1;
                        if (q.bidx == 2'd3 && q.cnt != CNT_W'(1)) set_f[FL_REFILL] = 1'b1;
                        n.st = SQ_RACK;
                    end else begin
                        n.bitn = q.bitn - 3'd1;
                    end
                end
                SQ_RACK: begin
                    if (q.cnt == '0) begin
                        n.st = SQ_STOP;
                    end else begin
                        n.st   = SQ_RBYTE;
                        n.bitn = 3'd7;
                    end
                end
                SQ_STOP: begin
                    n.st = SQ_IDLE;
                    if (!q.err) set_f[FL_DONE] = 1'b1;
                end
                default: ;
            endcase
        end

        if (q.st == SQ_WAIT && q.wfull) do_load = 1'b1;

        if (ack_ok) begin
            if (q.cnt == '0) begin
                n.st = SQ_STOP;
            end else if (q.dir) begin
                n.st   = SQ_RBYTE;
                n.bitn = 3'd7;
            end else if (q.wfull) begin
                do_load = 1'b1;
            end else begin
                n.st = SQ_WAIT;
            end
        end

        if (do_load) begin
            n.sh   = q.data[byte_lsb +: 8];
            n.bitn = 3'd7;
            n.st   = SQ_WBYTE;
            n.cnt  = q.cnt - 1'b1;
            n.bidx = q.bidx + 2'd1;
            if (q.bidx == 2'd3) begin
                n.wfull = 1'b0;
                if (q.cnt != CNT_W'(1)) set_f[FL_REFILL] = 1'b1;
            end
        end

        n.flags = (q.flags & ~clr_f) | set_f;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.st  <= SQ_IDLE;
            q.div <= DIV_RESET;
        end else begin
            q <= n;
        end
    end

    logic sda_lvl, scl_lvl;
    assign sda_lvl = q.swm ? q.swsda : phy_sda;
    assign scl_lvl = q.swm ? q.swscl : phy_scl;
    assign sda_oe  = ~sda_lvl;
    assign scl_oe  = ~scl_lvl;
    assign irq     = |(q.flags & q.ie);

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = (32'(q.div) << DIV_LSB)
                                | {20'd0, q.swscl, q.swsda, q.swm, q.en, 4'd0, q.ie};
            REG_TGT:  reg_rdata = (32'(q.cnt) << CNT_LSB) | {24'd0, q.dir, q.slv};
            REG_DATA: reg_rdata = q.data;
            default:  reg_rdata = {25'd0, (q.st != SQ_IDLE), scl_in, sda_in, q.flags};
        endcase
    end

    // R3: apart from a target write, the byte total only ever steps down by one
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(tgt_wr) && q.cnt != $past(q.cnt)) |-> q.cnt == $past(q.cnt) - 1'b1);

    // R6: an unanswered address leaves the byte total untouched
    assert_anack_count_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(q.flags[FL_ANACK]) |-> $stable(q.cnt));

    // R5: completion is reported only once the STOP has released both lines
    assert_done_released_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(q.flags[FL_DONE]) |-> (phy_sda && phy_scl));

    // R11: a disabled idle block stays idle
    assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(q.st) == SQ_IDLE && !$past(q.en)) |-> q.st == SQ_IDLE);
endmodule

// File: tb/i2c_word_master_bench.sv
module i2c_word_master_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [6:0]  SLV        = 7'h3C;
    localparam logic [31:0] SLV_TX     = 32'hC35A0F96;
    localparam logic [15:0] DIV_Q      = 16'd1;

    typedef struct packed {
        logic        dir;
        logic [7:0]  cnt;
        logic [31:0] word;
        logic [7:0]  nack_at;
        logic [3:0]  flags;
        logic [7:0]  rem;
        logic [31:0] exp_word;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 8'd4, 32'h11223344, 8'hFF, 4'b0001, 8'd0, 32'h0},
        '{1'b0, 8'd2, 32'hA5C3F00F, 8'hFF, 4'b0001, 8'd0, 32'h0},
        '{1'b1, 8'd3, 32'h00000000, 8'hFF, 4'b0001, 8'd0, 32'hC35A0F00},
        '{1'b1, 8'd1, 32'h00000000, 8'hFF, 4'b0001, 8'd0, 32'hC3000000},
        '{1'b0, 8'd3, 32'hDEADBEEF, 8'd1,  4'b0100, 8'd1, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, scl_oe, sda_oe;
    logic        scl_line, sda_line;
    logic        s_drive = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | s_drive);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_word_master u_i2c_word_master (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .scl_in    (scl_line),
        .sda_in    (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    // ---------------- behavioural target ----------------
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         s_cnt = 0;
    logic       s_first = 1'b0, s_tx = 1'b0, s_rw = 1'b0, s_ackaddr = 1'b0, s_mnack = 1'b0;
    logic [7:0] s_sh = '0, s_txb = '0, s_addr_seen = '0;
    int         s_txk = 0;
    logic [7:0] s_log [0:63];
    logic       s_mack [0:63];
    int         s_nlog = 0, s_nmack = 0;
    int         nack_abs = -1;

    function automatic logic [7:0] slave_byte(input int k);
        return SLV_TX[8*(3 - (k % 4)) +: 8];
    endfunction

    always @(scl_line, sda_line) begin
        if (scl_line === 1'b1 && p_scl === 1'b1 && p_sda === 1'b1 && sda_line === 1'b0) begin
            s_cnt = 0; s_first = 1'b1; s_tx = 1'b0; s_drive = 1'b0;
        end else if (scl_line === 1'b1 && p_scl === 1'b0) begin
            if (s_cnt < 8 && !s_tx) s_sh = {s_sh[6:0], sda_line};
            if (s_cnt == 8 && s_tx) s_mnack = sda_line;
            s_cnt = s_cnt + 1;
        end else if (scl_line === 1'b0 && p_scl === 1'b1) begin
            if (s_cnt == 8) begin
                if (s_tx) begin
                    s_drive = 1'b0;
                end else if (s_first) begin
                    s_addr_seen = s_sh;
                    s_ackaddr   = (s_sh[7:1] == SLV);
                    s_rw        = s_sh[0];
                    s_drive     = s_ackaddr;
                end else begin
                    s_log[s_nlog % 64] = s_sh;
                    s_drive = (s_nlog != nack_abs);
                    s_nlog  = s_nlog + 1;
                end
            end else if (s_cnt == 9) begin
                s_cnt = 0; s_drive = 1'b0;
                if (s_first) begin
                    s_first = 1'b0;
                    if (s_rw && s_ackaddr) begin
                        s_tx = 1'b1; s_txk = 0; s_txb = slave_byte(0); s_drive = ~s_txb[7];
                    end
                end else if (s_tx) begin
                    s_mack[s_nmack % 64] = s_mnack;
                    s_nmack = s_nmack + 1;
                    if (s_mnack) s_tx = 1'b0;
                    else begin
                        s_txk = s_txk + 1; s_txb = slave_byte(s_txk); s_drive = ~s_txb[7];
                    end
                end
            end else if (s_tx && s_cnt >= 1 && s_cnt <= 7) begin
                s_drive = ~s_txb[7 - s_cnt];
            end
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [3:0] ie, input logic [3:0] clr,
                                              input logic en, input logic swm,
                                              input logic swsda, input logic swscl);
        return {DIV_Q, 4'd0, swscl, swsda, swm, en, clr, ie};
    endfunction

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd3, st);
            if (!st[6]) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int base, mbase, nexp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13: reset state
        rd(2'd3, r);
        check("R13 status after reset", r, 32'h30);
        check("R13 irq after reset", {31'd0, irq}, 32'd0);

        // R11: disabled block ignores data write
        base = s_nlog;
        wr(2'd0, ctrl_word(4'h0, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1));
        wr(2'd1, {16'd0, 8'd2, 1'b0, SLV});
        wr(2'd2, 32'h12345678);
        repeat (60) @(negedge clk);
        rd(2'd3, r);
        check("R11 busy while disabled", {31'd0, r[6]}, 32'd0);
        check("R11 lines released", {30'd0, scl_line, sda_line}, 32'd3);
        check("R11 no bytes on bus", s_nlog - base, 32'd0);

        // table of transfers: R1 R2 R5 R7
        for (int i = 0; i < 5; i++) begin
            base  = s_nlog;
            mbase = s_nmack;
            nack_abs = (VECS[i].nack_at == 8'hFF) ? -1 : base + int'(VECS[i].nack_at);
            wr(2'd0, ctrl_word(4'h0, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1));
            wr(2'd1, {16'd0, VECS[i].cnt, VECS[i].dir, SLV});
            wr(2'd2, VECS[i].word);
            wait_idle();
            rd(2'd3, r);
            check("R5/R7 flags after transfer", {28'd0, r[3:0]}, {28'd0, VECS[i].flags});
            rd(2'd1, r);
            check("R3 remaining count", {24'd0, r[15:8]}, {24'd0, VECS[i].rem});
            check("R1 address byte", {24'd0, s_addr_seen}, {24'd0, SLV, VECS[i].dir});
            if (!VECS[i].dir) begin
                nexp = (VECS[i].nack_at == 8'hFF) ? int'(VECS[i].cnt) : int'(VECS[i].nack_at) + 1;
                check("R2 bytes written", s_nlog - base, nexp);
                for (int k = 0; k < nexp; k++)
                    check("R2 byte order", {24'd0, s_log[(base + k) % 64]},
                          {24'd0, VECS[i].word[8*(3-k) +: 8]});
            end else begin
                rd(2'd2, r);
                check("R5 read packing", r, VECS[i].exp_word);
                for (int k = 0; k < int'(VECS[i].cnt); k++)
                    check("R5 master ack/nack", {31'd0, s_mack[(mbase + k) % 64]},
                          {31'd0, (k == int'(VECS[i].cnt) - 1)});
            end
        end

        // R3 R4: two-word write with refill stall
        base = s_nlog;
        nack_abs = -1;
        wr(2'd0, ctrl_word(4'h8, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1));
        wr(2'd1, {16'd0, 8'd6, 1'b0, SLV});
        wr(2'd2, 32'h01020304);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq) break;
        end
        rd(2'd1, r);
        check("R3 count drops at load", {24'd0, r[15:8]}, 32'd2);
        check("R3 fourth byte not yet on bus", s_nlog - base, 32'd3);
        rd(2'd3, r);
        check("R4 refill flag", {31'd0, r[3]}, 32'd1);
        repeat (200) @(negedge clk);
        check("R4 stall holds SCL low", {31'd0, scl_line}, 32'd0);
        check("R4 stall after word drained", s_nlog - base, 32'd4);
        wr(2'd2, 32'h05060708);
        wr(2'd0, ctrl_word(4'h8, 4'h8, 1'b1, 1'b0, 1'b1, 1'b1));
        wait_idle();
        rd(2'd3, r);
        check("R4 done after refill", {28'd0, r[3:0]}, 32'h1);
        check("R2 six bytes", s_nlog - base, 32'd6);
        for (int k = 0; k < 6; k++)
            check("R2 two-word order", {24'd0, s_log[(base + k) % 64]}, k + 1);

        // R6 R8 R9: wrong address
        base = s_nlog;
        wr(2'd0, ctrl_word(4'h0, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1));
        wr(2'd1, {16'd0, 8'd2, 1'b0, 7'h11});
        wr(2'd2, 32'hAABBCCDD);
        wait_idle();
        rd(2'd3, r);
        check("R6 address nack flag only", {28'd0, r[3:0]}, 32'h2);
        rd(2'd1, r);
        check("R6 count unchanged", {24'd0, r[15:8]}, 32'd2);
        check("R6 no data bytes", s_nlog - base, 32'd0);
        check("R9 irq masked", {31'd0, irq}, 32'd0);
        wr(2'd0, ctrl_word(4'h2, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1));
        @(negedge clk);
        check("R9 irq enabled", {31'd0, irq}, 32'd1);
        wr(2'd0, ctrl_word(4'h2, 4'h1, 1'b1, 1'b0, 1'b1, 1'b1));
        rd(2'd3, r);
        check("R8 other flag kept", {28'd0, r[3:0]}, 32'h2);
        wr(2'd0, ctrl_word(4'h2, 4'h2, 1'b1, 1'b0, 1'b1, 1'b1));
        rd(2'd3, r);
        check("R8 flag cleared", {28'd0, r[3:0]}, 32'h0);
        check("R9 irq drops", {31'd0, irq}, 32'd0);

        // R1: zero-length write
        base = s_nlog;
        wr(2'd1, {16'd0, 8'd0, 1'b0, SLV});
        wr(2'd2, 32'h0);
        wait_idle();
        rd(2'd3, r);
        check("R1 zero count done", {28'd0, r[3:0]}, 32'h1);
        check("R1 zero count no data", s_nlog - base, 32'd0);
        check("R1 zero count address", {24'd0, s_addr_seen}, {24'd0, SLV, 1'b0});

        // R10: software line mode
        wr(2'd0, ctrl_word(4'h0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1));
        rd(2'd3, r);
        check("R10 sw SDA low", {31'd0, sda_line}, 32'd0);
        check("R10 status SDA", {31'd0, r[4]}, 32'd0);
        wr(2'd0, ctrl_word(4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0));
        rd(2'd3, r);
        check("R10 status SCL", {31'd0, r[5]}, 32'd0);
        wr(2'd2, 32'h55555555);
        repeat (20) @(negedge clk);
        rd(2'd3, r);
        check("R10 no start in sw mode", {31'd0, r[6]}, 32'd0);
        wr(2'd0, ctrl_word(4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1));
        rd(2'd3, r);
        check("R10 lines back to engine", {26'd0, r[5:4]}, 32'h3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule